// File: doc/BRIEF.md
# Staged escalation watchdog timer

This block is a hardware watchdog for one processor core. Software writes a 16-bit length and a 2-bit mode. The length is placed in the upper bits of a 24-bit down-counter, and the lower 8 bits are cleared. A free-running prescaler produces one tick every `PRESCALE` clocks, and the counter decrements once per tick. Software must keep the counter from running out by pulsing `poke`.

Each time the counter underflows while software is silent, the block moves up one escalation level and reloads. The first underflow raises an interrupt. The second raises a non-maskable interrupt. The third sends a one-cycle soft-reset request. The mode sets how many of these levels are allowed. When the last allowed level is reached, the counter stops at zero and the outputs hold. The block only produces the request signals. Routing them to cores or to the reset logic is done outside the block.

Top module: `stage_wdog`

## Requirements
- R1: After reset, `count` is 0, `stage` is 0, the mode is off (0), and `irq`, `nmi` and `soft_rst` are low.
- R2: A cycle with `cfg_we` high latches `cfg_len` and `cfg_mode`. On the next edge `count` becomes `{cfg_len, 8'h00}`, `stage` becomes 0, and `irq` and `nmi` clear. `cfg_we` takes priority over `poke` in the same cycle.
- R3: The prescaler is never cleared except by reset. A tick occurs on every edge where the prescaler value was `PRESCALE-1`, so the ticks land on edges `PRESCALE`, `2*PRESCALE`, and so on after reset. On a tick, an armed watchdog with a nonzero count decrements by one.
- R4: The first underflow sets `irq` (level) and `stage` to 1. An underflow is a tick while the count is 0 and the mode is nonzero.
- R5: With mode 2 or 3, the underflow in stage 1 sets `nmi` (level) and `stage` to 2, and `irq` stays high.
- R6: With mode 3, the underflow in stage 2 drives `soft_rst` high for exactly one cycle and sets `stage` to 3.
- R7: The mode encoding is 0 = off, 1 = interrupt only, 2 = interrupt then NMI, 3 = interrupt, NMI, then soft reset. Below the last enabled stage, every underflow reloads `{len, 8'h00}`. Entering stage equal to the mode sets `count` to 0. From then on the count and stage stay frozen, the level outputs hold, and no further pulse occurs.
- R8: `poke` without `cfg_we` reloads `{len, 8'h00}`, returns `stage` to 0, and clears `irq` and `nmi`. This includes recovery from the NMI stage.
- R9: With mode 0 (including the all-zero configuration word), ticks have no effect: the count holds and all request outputs stay low.
- R10: A length of 0 with a nonzero mode underflows on the first tick after the write.
- R11: `count` and `stage` show the live counter and escalation level at every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | 16 | Length, upper bits of the reload value |
| cfg_mode | input | 2 | Escalation depth (0 off .. 3 full) |
| poke | input | 1 | Service strobe from software |
| count | output | 24 | Current down-counter value |
| stage | output | 2 | Current escalation level |
| irq | output | 1 | Interrupt request, level |
| nmi | output | 1 | Non-maskable interrupt request, level |
| soft_rst | output | 1 | Soft-reset request, one-cycle pulse |

## Verification
Several kinds of internal fault show up on `count`, and they show up quickly:
- A wrong prescaler phase moves each decrement, and `count` is wrong at the first tick, within `PRESCALE` clocks.
- A wrong reload value appears on `count` on the edge after a write, a poke or an underflow.

A faulty stage register can stay hidden for a whole period. It becomes visible at the next underflow, when `irq`, `nmi` or `soft_rst` rises one level early or late. It can also be seen when the counter fails to freeze, which the cycle-by-cycle comparison of `count` and `stage` catches on that same edge.

// File: rtl/stage_wdog.sv
module stage_wdog #(
  parameter int PRESCALE = 256,
  parameter int LEN_W    = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [LEN_W-1:0]          cfg_len,
  input  logic [1:0]                cfg_mode,
  input  logic                      poke,
  output logic [LEN_W+FRAC_W-1:0]   count,
  output logic [1:0]                stage,
  output logic                      irq,
  output logic                      nmi,
  output logic                      soft_rst
);
  localparam int CNT_W = LEN_W + FRAC_W;
  localparam int PS_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]  presc;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] count_q;
  logic [1:0]       stage_q;
  logic             irq_q, nmi_q, srst_q;

  wire              tick      = (presc == PS_W'(PRESCALE - 1));
  wire [CNT_W-1:0]  reload    = {len_q, {FRAC_W{1'b0}}};
  wire              active    = (mode_q != 2'd0) && (stage_q < mode_q);
  wire              expire    = active && tick && (count_q == '0) && !cfg_we && !poke;
  wire [1:0]        nxt_stage = stage_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    presc <= '0;
    else if (tick) presc <= '0;
    else           presc <= presc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      mode_q  <= 2'd0;
      count_q <= '0;
      stage_q <= 2'd0;
      irq_q   <= 1'b0;
      nmi_q   <= 1'b0;
    end else if (cfg_we) begin
      len_q   <= cfg_len;
      mode_q  <= cfg_mode;
      count_q <= {cfg_len, {FRAC_W{1'b0}}};
      stage_q <= 2'd0;
      irq_q   <= 1'b0;
      nmi_q   <= 1'b0;
    end else if (poke) begin
      count_q <= reload;
      stage_q <= 2'd0;
      irq_q   <= 1'b0;
      nmi_q   <= 1'b0;
    end else if (expire) begin
      stage_q <= nxt_stage;
      count_q <= (nxt_stage == mode_q) ? '0 : reload;
      irq_q   <= 1'b1;
      if (nxt_stage >= 2'd2) nmi_q <= 1'b1;
    end else if (active && tick) begin
      count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= expire && (nxt_stage == 2'd3);

  assign count    = count_q;
  assign stage    = stage_q;
  assign irq      = irq_q;
  assign nmi      = nmi_q;
  assign soft_rst = srst_q;

  a_r5_nmi_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> irq);

  a_r6_reset_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  a_r6_reset_pulse_stage: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (stage == 2'd3) && nmi);

  a_r7_stage_capped: assert property (@(posedge clk) disable iff (!rst_n)
    stage <= mode_q);

  a_r7_frozen_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd0 && stage == mode_q && !poke && !cfg_we)
      |=> $stable(count) && $stable(stage) && !soft_rst);

  a_r8_poke_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (poke && !cfg_we) |=> stage == 2'd0 && !irq && !nmi
      && count == {$past(len_q), {FRAC_W{1'b0}}});

  a_r9_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !irq && !nmi && !soft_rst && stage == 2'd0);

  a_r4_irq_rise_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> stage == 2'd1);
endmodule

// File: tb/stage_wdog_tb.sv
module stage_wdog_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [1:0]  cfg_mode = '0;
  logic        poke = 1'b0;
  logic [23:0] count;
  logic [1:0]  stage;
  logic        irq, nmi, soft_rst;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  int srst_seen = 0;

  int m_presc, m_cnt, m_stage, m_mode, m_len;
  bit m_irq, m_nmi, m_srst, m_tick;

  always #10 clk = ~clk;

  stage_wdog #(.PRESCALE(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .count(count), .stage(stage),
    .irq(irq), .nmi(nmi), .soft_rst(soft_rst));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_presc = 0; m_cnt = 0; m_stage = 0; m_mode = 0; m_len = 0;
      m_irq = 0; m_nmi = 0; m_srst = 0;
    end else begin
      m_tick = (m_presc == P - 1);
      m_presc = m_tick ? 0 : m_presc + 1;
      m_srst = 0;
      if (cfg_we) begin
        m_len = cfg_len; m_mode = cfg_mode; m_cnt = cfg_len * 256;
        m_stage = 0; m_irq = 0; m_nmi = 0;
      end else if (poke) begin
        m_cnt = m_len * 256; m_stage = 0; m_irq = 0; m_nmi = 0;
      end else if (m_mode != 0 && m_tick && m_stage < m_mode) begin
        if (m_cnt == 0) begin
          m_stage = m_stage + 1;
          m_cnt = (m_stage == m_mode) ? 0 : m_len * 256;
          m_irq = 1;
          if (m_stage >= 2) m_nmi = 1;
          if (m_stage == 3) m_srst = 1;
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(count == 24'(m_cnt), {cur_req, "/R11 count"}, count, m_cnt);
    check(stage == 2'(m_stage), {cur_req, "/R11 stage"}, stage, m_stage);
    check(irq == m_irq, {cur_req, " irq"}, irq, m_irq);
    check(nmi == m_nmi, {cur_req, " nmi"}, nmi, m_nmi);
    check(soft_rst == m_srst, {cur_req, " soft_rst"}, soft_rst, m_srst);
    if (soft_rst) srst_seen++;
  end

  task automatic cfg(input int len, input int mode);
    @(negedge clk); cfg_we = 1'b1; cfg_len = 16'(len); cfg_mode = 2'(mode);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_poke();
    @(negedge clk); poke = 1'b1;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check(count == 0 && stage == 0 && !irq && !nmi && !soft_rst, "R1 reset", count, 0);
    rst_n = 1'b1;
    cur_req = "R3"; wait_cyc(10);

    cur_req = "R2"; cfg(1, 3);
    check(count == 24'd256 && stage == 0, "R2 load", count, 256);
    cur_req = "R4"; wait_cyc(1040);
    check(irq && !nmi && stage == 1, "R4 irq stage", stage, 1);
    cur_req = "R5"; wait_cyc(1030);
    check(nmi && irq && stage == 2, "R5 nmi stage", stage, 2);
    srst_seen = 0;
    cur_req = "R6"; wait_cyc(1030);
    check(srst_seen == 1 && stage == 3, "R6 one pulse", srst_seen, 1);
    cur_req = "R7"; wait_cyc(2100);
    check(srst_seen == 1 && count == 0 && irq && nmi, "R7 frozen", srst_seen, 1);

    cur_req = "R8"; cfg(1, 2); wait_cyc(2070);
    check(nmi && stage == 2 && count == 0, "R8 reach nmi", stage, 2);
    do_poke();
    check(!nmi && !irq && stage == 0 && count == 256, "R8 poke from nmi", count, 256);
    repeat (6) begin wait_cyc(500); do_poke(); end
    check(!irq && stage == 0, "R8 kept alive", irq, 0);

    cur_req = "R10"; cfg(0, 1);
    check(count == 0 && !irq, "R10 before tick", irq, 0);
    wait_cyc(P + 1);
    check(irq && stage == 1 && count == 0, "R10 first tick underflow", stage, 1);
    cur_req = "R7"; wait_cyc(40);
    check(stage == 1 && !nmi, "R7 mode1 holds", stage, 1);

    cur_req = "R9"; cfg(5, 0); wait_cyc(60);
    check(count == 1280 && !irq && stage == 0, "R9 off holds", count, 1280);
    cfg(0, 0); wait_cyc(30);
    check(count == 0 && !irq && !nmi && !soft_rst, "R9 all zero", count, 0);

    cur_req = "R2"; cfg(2, 1);
    @(negedge clk); cfg_we = 1'b1; poke = 1'b1; cfg_len = 16'd3; cfg_mode = 2'd2;
    @(negedge clk); cfg_we = 1'b0; poke = 1'b0;
    check(count == 768, "R2 cfg beats poke", count, 768);
    cur_req = "R3"; wait_cyc(40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule